// File: doc/BRIEF.md
# Latched Eight-Way Bit Selector with Gated Complementary Outputs

This block picks one bit out of eight data bits using a three-bit address. Both the address and the eight data bits first go through their own hold stage. Each hold stage takes new values while its active-low load control is asserted. It keeps its contents while that control is released. The two controls are independent, so a caller can freeze the address and keep sampling data, or freeze a data word and scan through addresses.

The selected bit is driven on a true output and a complementary output. A separate output-enable flag is formed without any clock from three enable pins of mixed polarity. A pad wrapper uses this flag to build real three-state drivers. The block has no streaming data path, so every pin is a plain level signal with no handshake.

The hold stages are clocked registers that load on each rising clock edge while their control is low. A value is captured if it is present in the last cycle the control was low. A synchronous, active-high reset clears both stages.

Top module: `latched_sel_mux`

## Requirements
- R1: While `sel_load_n` is 0 at a rising clock edge, the address stage takes `sel_in`, and the selection reflects it after that edge.
- R2: While `sel_load_n` is 1 at a rising edge, the stored address does not change, whatever `sel_in` does.
- R3: While `dat_load_n` is 0 at a rising edge, the data stage takes `dat_in`, and the outputs reflect it after that edge.
- R4: While `dat_load_n` is 1 at a rising edge, the stored data word does not change, whatever `dat_in` does.
- R5: The two stages are independent. Freezing one stage does not stop the other from loading.
- R6: `y_true` equals bit number A of the stored data word, where A is the stored address read as an unsigned number. Bit 2 of `sel_in` is the most significant address bit and bit 0 is the least significant.
- R7: `y_comp` is always the inverse of `y_true`.
- R8: `out_en` is 1 exactly when `en_lo_a` is 0, `en_lo_b` is 0 and `en_hi` is 1. The flag changes in the same cycle as the enable inputs, with no clock involved.
- R9: A synchronous reset (`rst` = 1 at a rising edge) clears both stages. After reset, `y_true` is 0 and `y_comp` is 1.
- R10: The enable inputs have no effect on the stored state or on `y_true`/`y_comp`. They only change `out_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the hold stages sample on its rising edge |
| rst | input | 1 | Synchronous active-high reset of both hold stages |
| dat_in | input | 8 | Eight data bits offered to the data hold stage |
| sel_in | input | 3 | Address offered to the address hold stage |
| sel_load_n | input | 1 | Active-low load control of the address stage |
| dat_load_n | input | 1 | Active-low load control of the data stage |
| en_lo_a | input | 1 | Active-low output enable, first |
| en_lo_b | input | 1 | Active-low output enable, second |
| en_hi | input | 1 | Active-high output enable |
| y_true | output | 1 | Selected stored bit, true form |
| y_comp | output | 1 | Selected stored bit, inverted |
| out_en | output | 1 | 1 when the wrapper should drive both outputs |

## Verification
Only one bit of the stored state reaches the ports at a time. A wrong stored data bit shows on `y_true` and `y_comp` in the cycle after the stored address first points at it. A wrong stored address shows once the stored word differs at the wrong and right positions. The stimulus therefore uses one-hot and inverted one-hot words while scanning every address, so any corrupted stage shows up within a single cycle of selection. An enable fault shows on `out_en` in the same cycle as the enable change.

// File: rtl/latched_sel_pkg.sv
package latched_sel_pkg;
  localparam int unsigned DEF_SEL_W = 3;

  typedef struct packed {
    logic lo_a;
    logic lo_b;
    logic hi;
  } oe_pins_t;
endpackage

// File: rtl/ls_hold_stage.sv
module ls_hold_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (!load_n) q <= d;
  end
endmodule

// File: rtl/ls_bit_pick.sv
module ls_bit_pick #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic [N-1:0]     word,
  input  logic [SEL_W-1:0] addr,
  output logic             bit_true,
  output logic             bit_comp
);
  logic [N-1:0] hit;

  // One-hot decode of the stored address, then AND-OR reduction.
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign hit[i] = (addr == SEL_W'(i)) & word[i];
  end

  assign bit_true = |hit;
  assign bit_comp = ~bit_true;
endmodule

// File: rtl/ls_oe_gate.sv
module ls_oe_gate
  import latched_sel_pkg::*;
(
  input  oe_pins_t pins,
  output logic     drive
);
  assign drive = ~pins.lo_a & ~pins.lo_b & pins.hi;
endmodule

// File: rtl/latched_sel_mux.sv
module latched_sel_mux
  import latched_sel_pkg::*;
#(
  parameter int unsigned SEL_W = DEF_SEL_W,
  localparam int unsigned N = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     dat_in,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             sel_load_n,
  input  logic             dat_load_n,
  input  logic             en_lo_a,
  input  logic             en_lo_b,
  input  logic             en_hi,
  output logic             y_true,
  output logic             y_comp,
  output logic             out_en
);
  logic [SEL_W-1:0] addr_q;
  logic [N-1:0]     word_q;
  oe_pins_t         oe_pins;

  ls_hold_stage #(.W(SEL_W)) u_addr_stage (
    .clk(clk), .rst(rst), .load_n(sel_load_n), .d(sel_in), .q(addr_q)
  );

  ls_hold_stage #(.W(N)) u_data_stage (
    .clk(clk), .rst(rst), .load_n(dat_load_n), .d(dat_in), .q(word_q)
  );

  ls_bit_pick #(.SEL_W(SEL_W)) u_pick (
    .word(word_q), .addr(addr_q), .bit_true(y_true), .bit_comp(y_comp)
  );

  assign oe_pins = '{lo_a: en_lo_a, lo_b: en_lo_b, hi: en_hi};

  ls_oe_gate u_oe (
    .pins(oe_pins), .drive(out_en)
  );
endmodule

// File: rtl/latched_sel_mux_chk.sv
module latched_sel_mux_chk #(
  parameter int unsigned SEL_W = 3,
  localparam int unsigned N = 1 << SEL_W
) (
  input logic             clk,
  input logic             rst,
  input logic [N-1:0]     dat_in,
  input logic [SEL_W-1:0] sel_in,
  input logic             sel_load_n,
  input logic             dat_load_n,
  input logic             en_lo_a,
  input logic             en_lo_b,
  input logic             en_hi,
  input logic             y_true,
  input logic             y_comp,
  input logic             out_en
);
  // R2 R4
  hold_both_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_load_n && dat_load_n) |=> $stable(y_true));

  // R1 R3 R6
  load_both_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_load_n && !dat_load_n) |=> (y_true == $past(dat_in[sel_in])));

  // R7
  comp_pair_chk: assert property (@(posedge clk) disable iff (rst)
    y_comp != y_true);

  // R8
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    (en_lo_a || en_lo_b || !en_hi) |-> !out_en);

  // R8
  oe_on_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_lo_a && !en_lo_b && en_hi) |-> out_en);

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!y_true && y_comp));
endmodule

bind latched_sel_mux latched_sel_mux_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/latched_sel_mux_bench.sv
module latched_sel_mux_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] dat_in = '0;
  logic [2:0] sel_in = '0;
  logic       sel_load_n = 1'b1, dat_load_n = 1'b1;
  logic       en_lo_a = 1'b0, en_lo_b = 1'b0, en_hi = 1'b1;
  logic       y_true, y_comp, out_en;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;
  logic [2:0] m_sel = '0;
  logic [7:0] m_dat = '0;

  always #4 clk = ~clk;  // 125 MHz

  latched_sel_mux u_latched_sel_mux (.*);

  function automatic logic exp_oe(logic a, logic b, logic c);
    return !a && !b && c;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive at negedge, check enable flag in same cycle, then update model at posedge and check outputs.
  task automatic step(logic [7:0] d, logic [2:0] s, logic sn, logic dn,
                      logic a, logic b, logic c, logic r, string tag);
    @(negedge clk);
    dat_in = d; sel_in = s; sel_load_n = sn; dat_load_n = dn;
    en_lo_a = a; en_lo_b = b; en_hi = c; rst = r;
    #1;
    chk(out_en == exp_oe(a, b, c), "R8 out_en", out_en, exp_oe(a, b, c));
    @(posedge clk);
    #1;
    if (r) begin m_sel = '0; m_dat = '0; end
    else begin
      if (!sn) m_sel = s;
      if (!dn) m_dat = d;
    end
    chk(y_true == m_dat[m_sel], tag, y_true, m_dat[m_sel]);
    chk(y_comp == ~m_dat[m_sel], "R7 y_comp", y_comp, ~m_dat[m_sel]);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    // R9 reset state
    step(8'hFF, 3'd5, 0, 0, 0, 0, 1, 1, "R9 reset clears");
    chk(y_true == 0 && y_comp == 1, "R9 post-reset pair", {y_true, y_comp}, 1);
    // R6 R1 R3: every address, one-hot and inverted one-hot words
    for (int i = 0; i < 8; i++) begin
      step(8'(1 << i), 3'(i), 0, 0, 0, 0, 1, 0, "R6 one-hot pick");
      step(~8'(1 << i), 3'(i), 0, 0, 0, 0, 1, 0, "R6 zero-hot pick");
    end
    // R5 R3: address frozen at 3, data keeps loading
    step(8'h08, 3'd3, 0, 0, 0, 0, 1, 0, "R1 load addr");
    step(8'hF7, 3'd6, 1, 0, 0, 0, 1, 0, "R5 R3 data flows, addr frozen");
    step(8'h08, 3'd0, 1, 0, 0, 0, 1, 0, "R5 R3 data flows again");
    // R5 R1: data frozen at 0x5A, address scans
    step(8'h5A, 3'd0, 0, 0, 0, 0, 1, 0, "R3 load word");
    for (int i = 0; i < 8; i++)
      step(8'hA5, 3'(i), 0, 1, 0, 0, 1, 0, "R5 R1 addr scans, data frozen");
    // R2 R4: both frozen, inputs toggle
    step(8'h01, 3'd1, 0, 0, 0, 0, 1, 0, "R1 load");
    step(8'hFE, 3'd2, 1, 1, 0, 0, 1, 0, "R2 R4 both held");
    step(8'h00, 3'd0, 1, 1, 0, 0, 1, 0, "R2 R4 still held");
    // R8 R10: all enable combinations, stages frozen
    for (int e = 0; e < 8; e++)
      step(8'h00, 3'd4, 1, 1, e[2], e[1], e[0], 0, "R10 enables leave y");
    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r = $urandom;
      step(8'($urandom), r[2:0], r[3], r[4], r[5], r[6], r[7], (r[15:8] == 0),
           "R6 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule